// File: doc/BRIEF.md
# Serial Result Port, Externally Clocked, with Cascade Input

This block is the converter side of a serial result port where the host supplies the bit clock. When the converter's `busy` flag falls, the finished result is copied into a shift register. The host then streams the word out MSB first by toggling `sclk`. Its clock only acts while the port is in external-clock mode, `cs_n` and `rd_n` are both low, and no conversion is running. The clock may run freely or in bursts, and it may rest high or low between bursts.

A cascade input `sdin` is captured on the clock edge opposite to the one that advances `sdout`. The captured bit enters the register at its LSB end. Several ports can therefore be chained, each `sdout` feeding the next port's `sdin`. The host then reads the nearest word and, with no idle clock in between, the word of the port behind it.

All pin inputs from the host are resynchronised into the core clock `clk`. Edges of `sclk` are detected in that domain, so `sclk` must stay well below `clk`. The result bus and `busy` come from on-chip logic and are used directly. Data moves only through the serial pins, so there is no valid/ready handshake. Back-pressure is the host's choice of when to clock.

Top module: `srp_slave_port`

## Requirements
- R1: After reset, `sdout_en` is 0 and `sdout` is 0.
- R2: On the first `clk` edge where `busy` is low after being high, `result` is loaded. From the next cycle, `sdout` shows `result[W-1]`.
- R3: With `inv_edge`=0, each falling `sclk` edge advances the register by one bit toward `sdout`, so the word leaves MSB first.
- R4: With `inv_edge`=1, the edges swap: rising `sclk` advances the word and falling `sclk` captures `sdin`.
- R5: `sdin` is captured on the capture edge and enters the LSB on the following advance edge. After W advances, the captured bits follow the local word with no gap, oldest first.
- R6: `sclk` has no effect unless `cs_n`=0 and `rd_n`=0.
- R7: `sclk` has no effect while `busy`=1 or while `ext_clk_sel`=0.
- R8: An advance edge that arrives before any capture edge since the last load is ignored. This lets a burst clock rest at the level just before the advance edge.
- R9: `sdout_en` is 1 exactly when `ext_clk_sel`=1 and the synchronised `cs_n` is 0. A 0 means the pin should be high-impedance.
- R10: A load overwrites any bits left unread in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| ext_clk_sel | input | 1 | 1 selects the externally clocked mode |
| inv_edge | input | 1 | 0: capture on rise, advance on fall; 1: swapped |
| busy | input | 1 | Conversion in progress; a fall loads the result |
| result | input | W | Finished conversion word |
| sclk | input | 1 | Host bit clock |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read |
| sdin | input | 1 | Cascade input from the upstream port |
| sdout | output | 1 | Serial data, MSB of the register |
| sdout_en | output | 1 | Output drive enable for the serial pin |

## Verification
The assertions check, on every cycle, the single-cycle behaviour: the load after `busy` falls, the one-bit advance, the capture of the cascade bit, the hold when the port is deselected or busy, and the dropped leading edge. Other behaviour only shows up in the bench's scenarios. These are complete words leaving MSB first in both edge polarities, and an upstream word following with no gap. They also include a burst that rests high, and a reload that cuts a partial read short.

// File: rtl/srp_pkg.sv
package srp_pkg;
  // one-cycle strobes decoded from the synchronised host clock
  typedef struct packed {
    logic capture;  // cascade input is sampled
    logic advance;  // register moves one bit toward sdout
  } srp_edge_t;

  localparam int SRP_SYNC_STAGES = 2;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srp_edge.sv
module srp_edge
  import srp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s,
  input  logic      inv_edge,
  output srp_edge_t evt
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sclk_s;
  end

  assign rise = sclk_s & ~prev_q;
  assign fall = ~sclk_s & prev_q;

  always_comb begin
    evt.capture = inv_edge ? fall : rise;
    evt.advance = inv_edge ? rise : fall;
  end
endmodule

// File: rtl/srp_shift.sv
module srp_shift
  import srp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         gate,
  input  srp_edge_t    evt,
  input  logic         sdin_s,
  output logic [W-1:0] word,
  output logic         cap_bit,
  output logic         cap_seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      cap_bit  <= 1'b0;
      cap_seen <= 1'b0;
    end else if (load) begin
      word     <= data;
      cap_bit  <= 1'b0;
      cap_seen <= 1'b0;
    end else if (gate) begin
      if (evt.capture) begin
        cap_bit  <= sdin_s;
        cap_seen <= 1'b1;
      end
      // a leading advance edge with nothing captured yet is dropped
      if (evt.advance && cap_seen) begin
        word <= {word[W-2:0], cap_bit};
      end
    end
  end
endmodule

// File: rtl/srp_slave_port.sv
module srp_slave_port
  import srp_pkg::*;
#(
  parameter int W = 16,
  parameter int SYNC = SRP_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk_sel,
  input  logic         inv_edge,
  input  logic         busy,
  input  logic [W-1:0] result,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         sdin,
  output logic         sdout,
  output logic         sdout_en
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_RST = 4'b0110;  // sclk, cs_n, rd_n, sdin

  logic [NPIN-1:0] pins_s;
  logic sclk_s, cs_s, rd_s, sdin_s;
  logic busy_q, load_w, gate_w;
  logic cap_evt, adv_evt, cap_bit, cap_seen;
  logic [W-1:0] word;
  srp_edge_t evt;

  srp_sync #(.N(NPIN), .STAGES(SYNC), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, cs_n, rd_n, sdin}),
    .q(pins_s)
  );
  assign {sclk_s, cs_s, rd_s, sdin_s} = pins_s;

  srp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .inv_edge(inv_edge), .evt(evt)
  );
  assign cap_evt = evt.capture;
  assign adv_evt = evt.advance;

  // busy history follows the pin even in reset so no spurious load appears
  always_ff @(posedge clk) busy_q <= busy;

  assign load_w = busy_q & ~busy;
  assign gate_w = ext_clk_sel & ~cs_s & ~rd_s & ~busy;

  srp_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_w), .data(result),
    .gate(gate_w), .evt(evt), .sdin_s(sdin_s),
    .word(word), .cap_bit(cap_bit), .cap_seen(cap_seen)
  );

  assign sdout    = word[W-1];
  assign sdout_en = ext_clk_sel & ~cs_s;
endmodule

// File: rtl/srp_slave_port_chk.sv
module srp_slave_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         ext_clk_sel,
  input logic         result_msb,
  input logic         sdout,
  input logic         sdout_en,
  input logic         load,
  input logic         gate,
  input logic         cap_evt,
  input logic         adv_evt,
  input logic         cap_seen,
  input logic         cap_bit,
  input logic         sdin_s,
  input logic [W-1:0] word
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> (sdout == $past(result_msb)));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && adv_evt && cap_seen && !load) |=>
      (word == {$past(word[W-2:0]), $past(cap_bit)}));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && cap_evt && !load) |=> (cap_bit == $past(sdin_s)));

  p_deselect_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !load) |=> $stable(word));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(word));

  p_lead_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !cap_seen && !load) |=> $stable(word));

  p_drive_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdout_en |-> ext_clk_sel);
endmodule

bind srp_slave_port srp_slave_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ext_clk_sel(ext_clk_sel),
  .result_msb(result[W-1]), .sdout(sdout), .sdout_en(sdout_en),
  .load(load_w), .gate(gate_w), .cap_evt(cap_evt), .adv_evt(adv_evt),
  .cap_seen(cap_seen), .cap_bit(cap_bit), .sdin_s(sdin_s), .word(word)
);

// File: tb/sim_srp_slave_port.sv
`timescale 1ns/1ps
module sim_srp_slave_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int HALF = 6;       // core cycles per sclk level
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n, ext_clk_sel, inv_edge, busy, sclk, cs_n, rd_n, sdin;
  logic [W-1:0] result;
  logic sdout, sdout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  val;
    string req;
  } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  srp_slave_port #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .inv_edge(inv_edge),
    .busy(busy), .result(result), .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n),
    .sdin(sdin), .sdout(sdout), .sdout_en(sdout_en)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sclk(logic v);
    sclk = v;
    tick(HALF);
  endtask

  task automatic pulse_busy(logic [W-1:0] w);
    result = w;
    busy = 1'b1;
    tick(3);
    busy = 1'b0;
    tick(3);
  endtask

  // host side: sample before each capture edge; upstream port changes sdin on advance edges
  task automatic read_bits(logic [W-1:0] own, logic [W-1:0] up, int nbits, string req);
    logic cap_lvl;
    cap_lvl = inv_edge ? 1'b0 : 1'b1;
    sdin = up[W-1];
    tick(HALF);
    for (int k = 0; k < nbits; k++) begin
      exp_t e;
      e.val = (k < W) ? own[W-1-k] : ((k < 2*W) ? up[2*W-1-k] : 1'b0);
      e.req = (k < W) ? req : "R5";
      exp_q.push_back(e);
      -> sample_ev;
      set_sclk(cap_lvl);
      sclk = ~cap_lvl;
      sdin = (k + 1 < W) ? up[W-2-k] : 1'b0;
      tick(HALF);
    end
  endtask

  // monitor: compare each host sample with the queued expectation
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard: got %b expected <none>", sdout);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, sdout, e.val);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_clk_sel = 1'b1; inv_edge = 1'b0; busy = 1'b0;
    sclk = 1'b0; cs_n = 1'b1; rd_n = 1'b1; sdin = 1'b0; result = '0;
    tick(5);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    check("R1", sdout_en, 1'b0);
    check("R1", sdout, 1'b0);

    // R2 load, R3 MSB-first, R5 cascade word follows with no gap
    pulse_busy(16'hB38D);
    check("R2", sdout, 1'b1);
    cs_n = 1'b0; rd_n = 1'b0;
    tick(HALF);
    check("R9", sdout_en, 1'b1);
    read_bits(16'hB38D, 16'h5E27, 2*W, "R3");
    cs_n = 1'b1; rd_n = 1'b1;
    tick(HALF);
    check("R9", sdout_en, 1'b0);

    // R6 clock ignored unless both selects are low
    pulse_busy(16'h6C91);
    cs_n = 1'b0;
    for (int i = 0; i < 3; i++) begin set_sclk(1'b1); set_sclk(1'b0); end
    check("R6", sdout, 1'b0);
    cs_n = 1'b1; rd_n = 1'b0;
    for (int i = 0; i < 3; i++) begin set_sclk(1'b1); set_sclk(1'b0); end
    check("R6", sdout, 1'b0);
    cs_n = 1'b0;
    read_bits(16'h6C91, 16'h0000, W, "R6");
    cs_n = 1'b1; rd_n = 1'b1;
    tick(HALF);

    // R7 clock ignored in internal mode and while busy
    pulse_busy(16'hA3C5);
    cs_n = 1'b0; rd_n = 1'b0;
    ext_clk_sel = 1'b0;
    for (int i = 0; i < 3; i++) begin set_sclk(1'b1); set_sclk(1'b0); end
    check("R7", sdout, 1'b1);
    check("R7", sdout_en, 1'b0);
    ext_clk_sel = 1'b1;
    busy = 1'b1;
    for (int i = 0; i < 3; i++) begin set_sclk(1'b1); set_sclk(1'b0); end
    check("R7", sdout, 1'b1);
    busy = 1'b0;
    tick(3);

    // R10 partial read cut short by a new load
    read_bits(16'hA3C5, 16'h0000, 5, "R3");
    pulse_busy(16'h4F1B);
    read_bits(16'h4F1B, 16'h0000, W, "R10");
    cs_n = 1'b1; rd_n = 1'b1;
    tick(HALF);

    // R4 swapped edges, with cascade
    set_sclk(1'b1);
    inv_edge = 1'b1;
    pulse_busy(16'h1E6B);
    cs_n = 1'b0; rd_n = 1'b0;
    read_bits(16'h1E6B, 16'hC0DE, 2*W, "R4");
    cs_n = 1'b1; rd_n = 1'b1;
    tick(HALF);

    // R8 clock resting high: the leading fall is dropped
    inv_edge = 1'b0;
    pulse_busy(16'h9247);
    cs_n = 1'b0; rd_n = 1'b0;
    tick(HALF);
    set_sclk(1'b0);
    check("R8", sdout, 1'b1);
    read_bits(16'h9247, 16'h0000, W, "R8");
    cs_n = 1'b1; rd_n = 1'b1;
    tick(HALF);
    check("R9", sdout_en, 1'b0);

    tick(2);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule